// File: doc/BRIEF.md
# I2C Bus Error Detector with Software Recovery

This block watches the two lines of an I2C bus and keeps track of the current position inside a frame. That position is the address byte, a data byte, or the acknowledge slot that closes each byte. A START or STOP condition that lands inside one of these fields is treated as a bus error. The block then raises its interrupt flag and reports status code 0x00. It also lets go of both bus lines and ignores the bus until software recovers it.

A simple register-style control port exposes four flags: a start request, a stop request, the interrupt flag and an acknowledge enable. Software recovers from a bus error by writing the stop request as 1 and the interrupt flag as 0 in a single write. The block then drops the interrupt and signals the surrounding controller to return to the idle, not-addressed slave state. Hardware clears the stop request one cycle later, and no STOP condition is sent on the bus. The transfer engine sits outside this block. It connects only through mode inputs (master, selected slave), line drive requests, a status event input and a frame phase output.

Arbitration is sampled only on rising SCL edges, against the level this block is releasing. Two masters that start a repeated START in the same cycle therefore do not see each other as an arbitration loss.

Top module: `i2c_berr_ctrl`

## Requirements
- R1: After reset, si_o, sta_o, sto_o, aa_o, scl_oe_o and sda_oe_o are 0. Whenever si_o is 0, status_o reads 0xF8.
- R2: Sampled SCL/SDA pass through two synchronizer flops and one history flop. A START (SDA falls while SCL is high) or a STOP (SDA rises while SCL is high) is an error when all of the following hold: the bus is inside a frame, at least two SCL rising edges of the current byte (address, data or acknowledge slot) have been counted, and is_master_i or slv_sel_i is 1. In that case si_o goes to 1 and status_o to 0x00 at the third clock edge after the line change.
- R3: A START or STOP is not an error, and leaves si_o unchanged, in three cases: when the bus is idle, when at most one SCL rise of the current byte has been counted, or when both is_master_i and slv_sel_i are 0.
- R4: While a bus error is pending, si_o stays 1 and status_o stays 0x00. Bus activity, status events and any control write other than the recovery write do not change this.
- R5: A recovery write (ctl_wr_i with ctl_sto_i=1 and ctl_si_i=0 while an error is pending) has these effects at the next edge: si_o becomes 0 (status_o 0xF8), sto_o reads 1, unaddr_o pulses for one cycle and phase_o returns to idle. sto_o is cleared by hardware at the edge after that.
- R6: The recovery write loads sta_o and aa_o from ctl_sta_i and ctl_aa_i. The recovery sequence itself leaves both unchanged.
- R7: scl_oe_o and sda_oe_o (1 = pull line low) follow drv_scl_low_i and drv_sda_low_i one edge later. They are forced to 0 while an error is pending and during the recovery cycle.
- R8: A repeated START at the first bit slot after an acknowledge, with this block also pulling SDA low as master, causes no arbitration loss and no bus error, and phase_o returns to address (1).
- R9: In master mode inside a frame, arb_lost_o pulses for one cycle when SCL rises during one of the eight data/address bits while sda_oe_o is 0 and the synchronized SDA is 0.
- R10: With si_o at 0 and no error pending, evt_i sets si_o to 1 and status_o to evt_code_i at the next edge.
- R11: Outside an error, a control write with ctl_si_i=0 clears si_o. Writing ctl_si_i=1 never sets si_o.
- R12: phase_o encodes 0 idle, 1 address byte, 2 data byte, 3 acknowledge slot (ninth SCL rise counted). A START enters address, and the SCL fall after an acknowledge moves to data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| is_master_i | input | 1 | Transfer engine is in a master mode |
| slv_sel_i | input | 1 | Transfer engine is an addressed slave |
| drv_scl_low_i | input | 1 | Engine request to pull SCL low |
| drv_sda_low_i | input | 1 | Engine request to pull SDA low |
| evt_i | input | 1 | Engine reports a new status |
| evt_code_i | input | 8 | Status code for evt_i |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_sta_i | input | 1 | Written start request |
| ctl_sto_i | input | 1 | Written stop request |
| ctl_si_i | input | 1 | Written interrupt flag (0 clears) |
| ctl_aa_i | input | 1 | Written acknowledge enable |
| status_o | output | 8 | Status code, 0xF8 when si_o is 0 |
| si_o | output | 1 | Interrupt flag |
| sta_o | output | 1 | Start request flag |
| sto_o | output | 1 | Stop request flag |
| aa_o | output | 1 | Acknowledge enable flag |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| arb_lost_o | output | 1 | One-cycle arbitration loss pulse |
| unaddr_o | output | 1 | One-cycle return-to-not-addressed-slave pulse |
| phase_o | output | 2 | Frame phase: 0 idle, 1 address, 2 data, 3 acknowledge |

## Verification
The embedded properties check several invariants on every cycle: the 0xF8 code whenever the flag is low, the 0x00 code and the held flag during a pending error, and released lines during error and recovery. They also check the one-cycle life of sto_o and unaddr_o in recovery, the untouched STA/AA bits, the bit counter range and the single-cycle arbitration pulse. Only the bench scenarios can show where an error is decided. That covers which START/STOP positions count as illegal, how the mode inputs gate detection, the simultaneous repeated START staying clean, and the exact three-edge latency from a line change to the status. The bench shows these by comparing every output against its behavioural model on each clock.

// File: rtl/i2c_berr_pkg.sv
package i2c_berr_pkg;
  localparam logic [7:0] ST_NONE   = 8'hF8;
  localparam logic [7:0] ST_BUSERR = 8'h00;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_ACK  = 2'd3
  } phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
      prev_q <= '1;
    end else begin
      pipe[0] <= raw_i;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev_q <= pipe[STAGES-1];
    end
  end

  assign cur_o  = pipe[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/i2c_frame_track.sv
module i2c_frame_track
  import i2c_berr_pkg::*;
#(
  parameter int DATA_BITS = 8,
  localparam int CNT_W    = $clog2(DATA_BITS + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_c,
  input  logic             scl_p,
  input  logic             sda_c,
  input  logic             sda_p,
  input  logic             freeze_i,
  input  logic             clear_i,
  output logic             start_o,
  output logic             stop_o,
  output logic             rise_o,
  output logic             in_frame_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [1:0]       phase_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_BITS + 1);

  logic             fall_w;
  logic             in_q, first_q;
  logic [CNT_W-1:0] cnt_q;
  phase_e           ph;

  always_comb begin
    start_o = sda_p & ~sda_c & scl_c & scl_p;
    stop_o  = ~sda_p & sda_c & scl_c & scl_p;
    rise_o  = ~scl_p & scl_c;
    fall_w  = scl_p & ~scl_c;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      in_q    <= 1'b0;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else if (!freeze_i) begin
      if (start_o) begin
        in_q    <= 1'b1;
        cnt_q   <= '0;
        first_q <= 1'b1;
      end else if (stop_o) begin
        in_q    <= 1'b0;
        cnt_q   <= '0;
        first_q <= 1'b0;
      end else if (in_q) begin
        if (rise_o && cnt_q != LAST) begin
          cnt_q <= cnt_q + 1'b1;
        end else if (fall_w && cnt_q == LAST) begin
          cnt_q   <= '0;
          first_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    if (!in_q)              ph = PH_IDLE;
    else if (cnt_q == LAST) ph = PH_ACK;
    else if (first_q)       ph = PH_ADDR;
    else                    ph = PH_DATA;
  end

  assign phase_o    = ph;
  assign in_frame_o = in_q;
  assign cnt_o      = cnt_q;

  // R12: the slot counter never passes the acknowledge slot
  assert_cnt_range_R12: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  // R12: an idle bus always carries a cleared counter
  assert_idle_cnt_R12: assert property (@(posedge clk) disable iff (rst)
    !in_q |-> cnt_q == '0);
endmodule

// File: rtl/i2c_arb_watch.sv
module i2c_arb_watch #(
  parameter int CNT_W     = 4,
  parameter int DATA_BITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  input  logic             master_i,
  input  logic             in_frame_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             sda_i,
  input  logic             released_i,
  input  logic             block_i,
  output logic             lost_o
);
  logic lost_q;

  always_ff @(posedge clk) begin
    if (rst) lost_q <= 1'b0;
    else     lost_q <= rise_i & master_i & in_frame_i & released_i & ~sda_i &
                       (cnt_i < CNT_W'(DATA_BITS)) & ~block_i;
  end

  assign lost_o = lost_q;

  // R9: the arbitration loss indication lasts exactly one cycle
  assert_arb_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    lost_q |=> !lost_q);
endmodule

// File: rtl/i2c_berr_ctrl.sv
module i2c_berr_ctrl
  import i2c_berr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_BITS   = 8,
  parameter int CODE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              is_master_i,
  input  logic              slv_sel_i,
  input  logic              drv_scl_low_i,
  input  logic              drv_sda_low_i,
  input  logic              evt_i,
  input  logic [CODE_W-1:0] evt_code_i,
  input  logic              ctl_wr_i,
  input  logic              ctl_sta_i,
  input  logic              ctl_sto_i,
  input  logic              ctl_si_i,
  input  logic              ctl_aa_i,
  output logic [CODE_W-1:0] status_o,
  output logic              si_o,
  output logic              sta_o,
  output logic              sto_o,
  output logic              aa_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              arb_lost_o,
  output logic              unaddr_o,
  output logic [1:0]        phase_o
);
  localparam int               CNT_W      = $clog2(DATA_BITS + 2);
  localparam logic [CNT_W-1:0] FIRST_SLOT = CNT_W'(1);

  logic [1:0]        ln_cur, ln_prev;
  logic              start_w, stop_w, rise_w, in_frame;
  logic [CNT_W-1:0]  cnt;
  logic              rec_go, berr;

  logic              si_q, sta_q, sto_q, aa_q, err_q, rec_q;
  logic              si_n, sta_n, sto_n, aa_n, err_n, rec_n;
  logic [CODE_W-1:0] code_q, code_n, status_q;
  logic              scl_oe_q, sda_oe_q;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .raw_i ({scl_i, sda_i}),
    .cur_o (ln_cur),
    .prev_o(ln_prev)
  );

  i2c_frame_track #(.DATA_BITS(DATA_BITS)) u_track (
    .clk       (clk),
    .rst       (rst),
    .scl_c     (ln_cur[1]),
    .scl_p     (ln_prev[1]),
    .sda_c     (ln_cur[0]),
    .sda_p     (ln_prev[0]),
    .freeze_i  (err_q),
    .clear_i   (rec_go),
    .start_o   (start_w),
    .stop_o    (stop_w),
    .rise_o    (rise_w),
    .in_frame_o(in_frame),
    .cnt_o     (cnt),
    .phase_o   (phase_o)
  );

  i2c_arb_watch #(.CNT_W(CNT_W), .DATA_BITS(DATA_BITS)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .rise_i    (rise_w),
    .master_i  (is_master_i),
    .in_frame_i(in_frame),
    .cnt_i     (cnt),
    .sda_i     (ln_cur[0]),
    .released_i(~sda_oe_q),
    .block_i   (err_q | rec_q),
    .lost_o    (arb_lost_o)
  );

  assign rec_go = ctl_wr_i & err_q & ctl_sto_i & ~ctl_si_i;
  assign berr   = (start_w | stop_w) & in_frame & (cnt > FIRST_SLOT) &
                  (is_master_i | slv_sel_i) & ~err_q & ~rec_q;

  always_comb begin
    si_n   = si_q;
    code_n = code_q;
    sta_n  = sta_q;
    sto_n  = sto_q;
    aa_n   = aa_q;
    err_n  = err_q;
    rec_n  = 1'b0;
    if (rec_q) sto_n = 1'b0;
    if (ctl_wr_i) begin
      sta_n = ctl_sta_i;
      aa_n  = ctl_aa_i;
      sto_n = ctl_sto_i;
      if (!ctl_si_i && !err_q) si_n = 1'b0;
    end
    if (rec_go) begin
      si_n  = 1'b0;
      err_n = 1'b0;
      rec_n = 1'b1;
    end
    if (evt_i && !si_n && !err_q && !rec_q) begin
      si_n   = 1'b1;
      code_n = evt_code_i;
    end
    if (berr) begin
      si_n   = 1'b1;
      code_n = ST_BUSERR;
      err_n  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      si_q     <= 1'b0;
      sta_q    <= 1'b0;
      sto_q    <= 1'b0;
      aa_q     <= 1'b0;
      err_q    <= 1'b0;
      rec_q    <= 1'b0;
      code_q   <= ST_NONE;
      status_q <= ST_NONE;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      si_q     <= si_n;
      sta_q    <= sta_n;
      sto_q    <= sto_n;
      aa_q     <= aa_n;
      err_q    <= err_n;
      rec_q    <= rec_n;
      code_q   <= code_n;
      status_q <= si_n ? code_n : ST_NONE;
      scl_oe_q <= drv_scl_low_i & ~(err_n | rec_n);
      sda_oe_q <= drv_sda_low_i & ~(err_n | rec_n);
    end
  end

  assign status_o = status_q;
  assign si_o     = si_q;
  assign sta_o    = sta_q;
  assign sto_o    = sto_q;
  assign aa_o     = aa_q;
  assign scl_oe_o = scl_oe_q;
  assign sda_oe_o = sda_oe_q;
  assign unaddr_o = rec_q;

  // R1: no pending flag means the no-information code
  assert_idle_code_R1: assert property (@(posedge clk) disable iff (rst)
    !si_q |-> status_q == ST_NONE);
  // R2: a pending error always shows the bus error code
  assert_err_code_R2: assert property (@(posedge clk) disable iff (rst)
    err_q |-> status_q == ST_BUSERR);
  // R4: the flag cannot drop while the error is pending
  assert_err_holds_si_R4: assert property (@(posedge clk) disable iff (rst)
    err_q |-> si_q);
  // R5: hardware clears the stop request after the recovery cycle
  assert_sto_autoclr_R5: assert property (@(posedge clk) disable iff (rst)
    (rec_q && !ctl_wr_i) |=> !sto_q);
  // R5: the recovery cycle lasts one clock and leaves the flag low
  assert_rec_single_R5: assert property (@(posedge clk) disable iff (rst)
    rec_q |-> !si_q && !err_q);
  // R6: recovery leaves the start and acknowledge bits alone
  assert_ctl_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (rec_q && !ctl_wr_i) |=> $stable(sta_q) && $stable(aa_q));
  // R7: both lines released during error and recovery
  assert_lines_free_R7: assert property (@(posedge clk) disable iff (rst)
    (err_q || rec_q) |-> !scl_oe_q && !sda_oe_q);
endmodule

// File: tb/i2c_berr_ctrl_tb.sv
`timescale 1ns/1ps
module i2c_berr_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1, sda = 1'b1;
  logic       master = 1'b0, sel = 1'b0;
  logic       drv_scl = 1'b0, drv_sda = 1'b0;
  logic       evt = 1'b0;
  logic [7:0] evt_code = 8'h00;
  logic       ctl_wr = 1'b0, ctl_sta = 1'b0, ctl_sto = 1'b0, ctl_si = 1'b0, ctl_aa = 1'b0;

  logic [7:0] status;
  logic       si, sta, sto, aa, scl_oe, sda_oe, arb_lost, unaddr;
  logic [1:0] phase;

  int checks = 0, errors = 0, cyc = 0;
  bit arb_seen = 1'b0, run_cmp = 1'b0;

  // behavioural reference state
  bit s1c, s1d, sc, sd, pc, pd;
  int m_cnt;
  bit m_in, m_first, m_si, m_sta, m_sto, m_aa, m_err, m_rec, m_sclo, m_sdao, m_arb;
  logic [7:0] m_code, m_status;

  always #2.5 clk = ~clk;

  i2c_berr_ctrl dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
    .is_master_i(master), .slv_sel_i(sel),
    .drv_scl_low_i(drv_scl), .drv_sda_low_i(drv_sda),
    .evt_i(evt), .evt_code_i(evt_code),
    .ctl_wr_i(ctl_wr), .ctl_sta_i(ctl_sta), .ctl_sto_i(ctl_sto),
    .ctl_si_i(ctl_si), .ctl_aa_i(ctl_aa),
    .status_o(status), .si_o(si), .sta_o(sta), .sto_o(sto), .aa_o(aa),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .arb_lost_o(arb_lost),
    .unaddr_o(unaddr), .phase_o(phase)
  );

  always @(posedge clk) begin
    bit st, sp, ri, fa, go, be, ar;
    bit n_si, n_sta, n_sto, n_aa, n_err, n_rec;
    logic [7:0] n_code;
    if (rst) begin
      s1c = 1; s1d = 1; sc = 1; sd = 1; pc = 1; pd = 1;
      m_cnt = 0; m_in = 0; m_first = 0; m_si = 0; m_sta = 0; m_sto = 0; m_aa = 0;
      m_err = 0; m_rec = 0; m_sclo = 0; m_sdao = 0; m_arb = 0;
      m_code = 8'hF8; m_status = 8'hF8;
    end else begin
      st = pd && !sd && sc && pc;
      sp = !pd && sd && sc && pc;
      ri = !pc && sc;
      fa = pc && !sc;
      go = ctl_wr && m_err && ctl_sto && !ctl_si;
      be = (st || sp) && m_in && m_cnt >= 2 && (master || sel) && !m_err && !m_rec;
      ar = ri && master && m_in && !m_sdao && !sd && m_cnt < 8 && !m_err && !m_rec;
      n_si = m_si; n_code = m_code; n_sta = m_sta; n_sto = m_sto; n_aa = m_aa;
      n_err = m_err; n_rec = 0;
      if (m_rec) n_sto = 0;
      if (ctl_wr) begin
        n_sta = ctl_sta; n_aa = ctl_aa; n_sto = ctl_sto;
        if (!ctl_si && !m_err) n_si = 0;
      end
      if (go) begin n_si = 0; n_err = 0; n_rec = 1; end
      if (evt && !n_si && !m_err && !m_rec) begin n_si = 1; n_code = evt_code; end
      if (be) begin n_si = 1; n_code = 8'h00; n_err = 1; end
      if (go) begin
        m_in = 0; m_cnt = 0; m_first = 0;
      end else if (!m_err) begin
        if (st) begin m_in = 1; m_cnt = 0; m_first = 1; end
        else if (sp) begin m_in = 0; m_cnt = 0; m_first = 0; end
        else if (m_in) begin
          if (ri && m_cnt != 9) m_cnt = m_cnt + 1;
          else if (fa && m_cnt == 9) begin m_cnt = 0; m_first = 0; end
        end
      end
      m_arb = ar;
      m_sclo = drv_scl && !(n_err || n_rec);
      m_sdao = drv_sda && !(n_err || n_rec);
      m_si = n_si; m_code = n_code; m_sta = n_sta; m_sto = n_sto; m_aa = n_aa;
      m_err = n_err; m_rec = n_rec;
      m_status = n_si ? n_code : 8'hF8;
      pc = sc; pd = sd; sc = s1c; sd = s1d; s1c = scl; s1d = sda;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int m_phase();
    if (!m_in) return 0;
    if (m_cnt == 9) return 3;
    if (m_first) return 1;
    return 2;
  endfunction

  always @(negedge clk) begin
    if (arb_lost) arb_seen = 1'b1;
    if (!rst && run_cmp) begin
      chk(status == m_status, "R2 status_o", status, m_status);
      chk(si == m_si, "R4 si_o", si, m_si);
      chk(sto == m_sto, "R5 sto_o", sto, m_sto);
      chk(unaddr == m_rec, "R5 unaddr_o", unaddr, m_rec);
      chk(sta == m_sta && aa == m_aa, "R6 sta_o aa_o", {sta, aa}, {m_sta, m_aa});
      chk(scl_oe == m_sclo && sda_oe == m_sdao, "R7 oe", {scl_oe, sda_oe}, {m_sclo, m_sdao});
      chk(arb_lost == m_arb, "R9 arb_lost_o", arb_lost, m_arb);
      chk(int'(phase) == m_phase(), "R12 phase_o", phase, m_phase());
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 60000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_t(input logic v);
    scl = 0; tick(3); sda = v; tick(3); scl = 1; tick(6); scl = 0; tick(3);
  endtask

  task automatic start_c();
    sda = 1; tick(3); scl = 1; tick(6); sda = 0; tick(6); scl = 0; tick(4);
  endtask

  task automatic stop_c();
    scl = 0; tick(3); sda = 0; tick(3); scl = 1; tick(6); sda = 1; tick(6);
  endtask

  task automatic byte_t(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_t(b[i]);
  endtask

  task automatic ctl_write(input logic a_sta, input logic a_sto, input logic a_si, input logic a_aa);
    ctl_sta = a_sta; ctl_sto = a_sto; ctl_si = a_si; ctl_aa = a_aa; ctl_wr = 1;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic pulse_evt(input logic [7:0] c);
    evt_code = c; evt = 1;
    @(negedge clk);
    evt = 0;
  endtask

  initial begin
    tick(4);
    rst = 0;
    run_cmp = 1;
    tick(1);
    // R1: reset state
    chk(status == 8'hF8 && !si, "R1 reset status", {si, status}, 8'hF8);
    chk(!sta && !sto && !aa && !scl_oe && !sda_oe, "R1 reset flags",
        {sta, sto, aa, scl_oe, sda_oe}, 0);

    // R3: complete legal transfer as addressed slave
    sel = 1;
    start_c(); byte_t(8'hA4); bit_t(0); byte_t(8'h3C); bit_t(0); stop_c();
    tick(4);
    chk(!si && status == 8'hF8, "R3 legal frame", {si, status}, 8'hF8);

    // R10/R11: engine event, write with SI=1, write with SI=0
    pulse_evt(8'h60);
    tick(1);
    chk(si && status == 8'h60, "R10 event code", status, 8'h60);
    ctl_write(0, 0, 1, 0);
    chk(si && status == 8'h60, "R11 SI write 1 ignored", status, 8'h60);
    ctl_write(0, 0, 0, 0);
    chk(!si && status == 8'hF8, "R11 SI cleared", status, 8'hF8);

    // R2: STOP inside address byte, lines being driven
    drv_scl = 1;
    start_c(); bit_t(1); bit_t(0); bit_t(1);
    stop_c();
    tick(2);
    chk(si && status == 8'h00, "R2 bus error", status, 8'h00);
    chk(!scl_oe, "R7 released on error", scl_oe, 0);

    // R4: activity ignored while error pending
    start_c(); bit_t(0); bit_t(1); stop_c();
    pulse_evt(8'h28);
    ctl_write(0, 0, 0, 0);
    ctl_write(0, 1, 1, 0);
    tick(2);
    chk(si && status == 8'h00, "R4 error held", status, 8'h00);

    // R5/R6: recovery write
    ctl_write(1, 1, 0, 1);
    chk(!si && status == 8'hF8 && sto && unaddr, "R5 recovery edge",
        {si, sto, unaddr}, 3'b011);
    tick(1);
    chk(!sto && !unaddr && phase == 2'd0, "R5 sto cleared", {sto, unaddr}, 0);
    chk(sta && aa, "R6 sta aa kept", {sta, aa}, 2'b11);
    drv_scl = 0;
    tick(2);

    // R3: illegal position but neither master nor selected
    sel = 0; master = 0;
    start_c(); bit_t(1); bit_t(1); bit_t(0); stop_c();
    tick(4);
    chk(!si, "R3 not involved", si, 0);

    // R8: simultaneous repeated START as master
    master = 1; arb_seen = 0;
    start_c(); byte_t(8'hFF); bit_t(0);
    scl = 0; tick(3); sda = 1; tick(3); scl = 1; tick(6);
    drv_sda = 1; tick(2); sda = 0; tick(6);
    scl = 0; tick(4);
    chk(!arb_seen && !si, "R8 no arb no error", {arb_seen, si}, 0);
    chk(phase == 2'd1, "R8 back to address", phase, 1);
    master = 0; drv_sda = 0;
    stop_c(); tick(4);

    // R9: arbitration loss on released SDA read low
    master = 1; arb_seen = 0;
    start_c(); bit_t(0);
    chk(arb_seen, "R9 arb lost", arb_seen, 1);
    master = 0;
    stop_c(); tick(4);
    chk(!si, "R3 uninvolved stop", si, 0);

    run_cmp = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule